// File: doc/BRIEF.md
# Phase-Qualified Register-File Memory with Idle-High Read Bus

This block is a small word-addressed memory for a clock-phase style datapath that has been folded onto one system clock. Every phase of the larger operating cycle is one clock edge. The read and write ports each carry a phase strobe, which acts as a clock enable, plus an enable bit and a word index. A read takes place only when its strobe and its enable are both high in the same clock. When no read takes place, the registered read bus rests at all ones, in the way a precharged bit line would.

A separate wipe input clears the whole array. The wipe does not end when the input falls. A two-state machine, with the states `WIPE_CLEAN` and `WIPE_HELD`, keeps it in force for the rest of the operating cycle. The transitions are:
- `WIPE_CLEAN -> WIPE_HELD` on any clock with `wipe` high.
- `WIPE_HELD -> WIPE_CLEAN` on a clock with `cycle_start` high and `wipe` low.
- In every other case the machine stays in its current state.

The wipe is in force on any clock where `wipe` is high. It is also in force in `WIPE_HELD` on any clock without `cycle_start`. While the wipe is in force, reads return zero and writes are dropped. The read and write ports are meant to be used in different phases. If both fire in one clock, a one-clock error pulse follows.

Top module: `phased_ram`

## Requirements
- R1: The array holds 2^IDX_W words of DATA_W bits. `rd_idx` and `wr_idx` are unsigned binary word numbers from 0 to 2^IDX_W-1.
- R2: A read fires only on a clock where `rd_phase` and `rd_en` are both 1. The word at `rd_idx` then appears on `rd_data` after that same edge, and can be sampled before the next edge.
- R3: After any clock without a fired read, `rd_data` is all ones. While `rst_n` is low and after its release, `rd_data` is all ones and `overlap_err` is 0.
- R4: A write fires on a clock where `wr_phase` and `wr_en` are both 1 and the wipe is not in force. The write replaces only the word at `wr_idx`, and a later read of that word returns `wr_data`.
- R5: On a clock where the wipe is in force, every word becomes 0. A fired read returns 0, and that word keeps reading 0 in later cycles until it is written again.
- R6: Once `wipe` has been seen, the wipe stays in force on every later clock until a clock with `cycle_start` 1 and `wipe` 0. Writes on the clocks in between have no effect.
- R7: On a clock with `cycle_start` 1 and `wipe` 0, the wipe is released on that same clock, so a write on that clock takes effect.
- R8: A word that receives neither a fired write nor a wipe keeps its value. A write strobe without its enable, or an enable without its strobe, changes nothing.
- R9: If a read and a write both fire on one clock, the read returns the contents from before that write and the write still completes. `overlap_err` is 1 for exactly the clock that follows, and 0 after any clock where both did not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; each edge is one phase |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_start | input | 1 | Marks the first phase of an operating cycle |
| wipe | input | 1 | Array clear, held for the rest of the cycle |
| rd_phase | input | 1 | Read phase strobe |
| rd_en | input | 1 | Read enable |
| rd_idx | input | IDX_W | Read word index |
| wr_phase | input | 1 | Write phase strobe |
| wr_en | input | 1 | Write enable |
| wr_idx | input | IDX_W | Write word index |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data; all ones when idle |
| overlap_err | output | 1 | Read and write fired on the previous clock |

## Verification
The bench concentrates on the wipe. Writes are attempted on the clocks that follow a wipe before any cycle start, and then read back after the release. A design that let the wipe lapse when its input fell would return the written data here instead of zero. The bench also writes on the very clock that releases the wipe. A design that released the wipe one clock late would lose that write. Half-qualified strobes are applied, to catch a design that decodes the strobe or the enable alone. A read and a write are sent to the same word on one clock, to catch a write-first bypass and a missing or stretched error pulse. The top index is also exercised.

// File: rtl/phased_ram_pkg.sv
package phased_ram_pkg;

    // Sticky wipe tracker states
    typedef enum logic {
        WIPE_CLEAN = 1'b0,
        WIPE_HELD  = 1'b1
    } wipe_state_e;

    // What the read register loads on this edge
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_WORD = 2'd1,
        RD_ZERO = 2'd2
    } rd_mode_e;

endpackage

// File: rtl/phased_ram_wipe.sv
module phased_ram_wipe
    import phased_ram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cycle_start,
    input  logic        wipe,
    output logic        wipe_now,
    output wipe_state_e state
);

    wipe_state_e state_q;
    wipe_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIPE_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIPE_CLEAN: if (wipe) state_d = WIPE_HELD;
            WIPE_HELD:  if (cycle_start && !wipe) state_d = WIPE_CLEAN;
            default:    state_d = WIPE_CLEAN;
        endcase
    end

    always_comb begin
        wipe_now = wipe;
        unique case (state_q)
            WIPE_CLEAN: wipe_now = wipe;
            WIPE_HELD:  wipe_now = wipe || !cycle_start;
            default:    wipe_now = wipe;
        endcase
        state = state_q;
    end

endmodule

// File: rtl/phased_ram_store.sv
module phased_ram_store #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe_now,
    input  logic              wr_go,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] words [1<<IDX_W]
);

    localparam int DEPTH = 1 << IDX_W;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic hit;
        assign hit = wr_go && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (wipe_now) begin
                words[g] <= '0;
            end else if (hit) begin
                words[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/phased_ram_rdport.sv
module phased_ram_rdport
    import phased_ram_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic              wr_req,
    input  logic              wipe_now,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] words [1<<IDX_W],
    output logic [DATA_W-1:0] rd_data,
    output logic              overlap_err
);

    rd_mode_e          mode;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        if (!rd_go) begin
            mode = RD_IDLE;
        end else if (wipe_now) begin
            mode = RD_ZERO;
        end else begin
            mode = RD_WORD;
        end
    end

    always_comb begin
        rd_next = '1;
        unique case (mode)
            RD_IDLE: rd_next = '1;
            RD_WORD: rd_next = words[rd_idx];
            RD_ZERO: rd_next = '0;
            default: rd_next = '1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data     <= '1;
            overlap_err <= 1'b0;
        end else begin
            rd_data     <= rd_next;
            overlap_err <= rd_go && wr_req;
        end
    end

endmodule

// File: rtl/phased_ram.sv
module phased_ram
    import phased_ram_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_start,
    input  logic              wipe,
    input  logic              rd_phase,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_phase,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              overlap_err
);

    localparam int DEPTH = 1 << IDX_W;

    logic              wipe_now;
    wipe_state_e       wipe_state;
    logic              rd_go;
    logic              wr_req;
    logic              wr_go;
    logic [DATA_W-1:0] words [DEPTH];

    assign rd_go  = rd_phase && rd_en;
    assign wr_req = wr_phase && wr_en;
    assign wr_go  = wr_req && !wipe_now;

    phased_ram_wipe u_wipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .wipe        (wipe),
        .wipe_now    (wipe_now),
        .state       (wipe_state)
    );

    phased_ram_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe_now (wipe_now),
        .wr_go    (wr_go),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .words    (words)
    );

    phased_ram_rdport #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_go       (rd_go),
        .wr_req      (wr_req),
        .wipe_now    (wipe_now),
        .rd_idx      (rd_idx),
        .words       (words),
        .rd_data     (rd_data),
        .overlap_err (overlap_err)
    );

endmodule

// File: rtl/phased_ram_chk.sv
module phased_ram_chk
    import phased_ram_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cycle_start,
    input logic              wipe,
    input logic              rd_phase,
    input logic              rd_en,
    input logic [IDX_W-1:0]  rd_idx,
    input logic              wr_phase,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              overlap_err,
    input wipe_state_e       wipe_state
);

    // R3: no fired read leaves the bus high
    p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_phase && rd_en) |=> rd_data == {DATA_W{1'b1}});

    // R5: a read on a wipe clock returns zero
    p_wipe_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_phase && rd_en && wipe) |=> rd_data == '0);

    // R9: overlap raises the error flag on the next clock
    p_overlap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_phase && rd_en && wr_phase && wr_en) |=> overlap_err);

    // R9: no overlap, no flag
    p_overlap_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_phase && rd_en && wr_phase && wr_en) |=> !overlap_err);

    // R6: the tracker leaves the held state only on a clean cycle start
    p_held_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_state == WIPE_HELD && !cycle_start) |=> wipe_state == WIPE_HELD);

    // R4: a write outside the wipe is returned by the next read of that word
    p_write_then_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n)
         && $past(wr_phase && wr_en && !wipe && (cycle_start || wipe_state == WIPE_CLEAN))
         && rd_phase && rd_en && !wipe && rd_idx == $past(wr_idx))
        |=> rd_data == $past(wr_data, 2));

endmodule

bind phased_ram phased_ram_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_start (cycle_start),
    .wipe        (wipe),
    .rd_phase    (rd_phase),
    .rd_en       (rd_en),
    .rd_idx      (rd_idx),
    .wr_phase    (wr_phase),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .overlap_err (overlap_err),
    .wipe_state  (wipe_state)
);

// File: tb/phased_ram_tb.sv
`timescale 1ns/1ps
module phased_ram_tb;

    localparam int IDX_W  = 3;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic             cs;
        logic             wp;
        logic             rp;
        logic             re;
        logic [2:0]       ri;
        logic             wph;
        logic             we;
        logic [2:0]       wi;
        logic [7:0]       wd;
        logic [7:0]       exp_rd;
        logic             exp_err;
    } vec_t;

    // cs wipe rph ren ri wph wen wi wd exp err
    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,3'd0,1'b1,1'b1,3'd1,8'hA5,8'hFF,1'b0}, // R4 write w1
        '{1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b1,3'd6,8'h3C,8'hFF,1'b0}, // R4 write w6
        '{1'b0,1'b0,1'b1,1'b1,3'd1,1'b0,1'b0,3'd0,8'h00,8'hA5,1'b0}, // R2 read w1
        '{1'b0,1'b0,1'b1,1'b0,3'd6,1'b0,1'b0,3'd0,8'h00,8'hFF,1'b0}, // R2 strobe only
        '{1'b0,1'b0,1'b0,1'b1,3'd6,1'b0,1'b0,3'd0,8'h00,8'hFF,1'b0}, // R2 enable only
        '{1'b0,1'b0,1'b1,1'b1,3'd6,1'b0,1'b0,3'd0,8'h00,8'h3C,1'b0}, // R2 read w6
        '{1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b1,3'd1,8'h00,8'hFF,1'b0}, // R8 half write
        '{1'b0,1'b0,1'b1,1'b1,3'd1,1'b0,1'b0,3'd0,8'h00,8'hA5,1'b0}, // R8 w1 kept
        '{1'b0,1'b0,1'b1,1'b1,3'd6,1'b1,1'b1,3'd6,8'h77,8'h3C,1'b1}, // R9 overlap
        '{1'b0,1'b0,1'b1,1'b1,3'd6,1'b0,1'b0,3'd0,8'h00,8'h77,1'b0}, // R9 write done
        '{1'b0,1'b0,1'b1,1'b1,3'd2,1'b0,1'b0,3'd0,8'h00,8'h00,1'b0}, // R4 neighbour
        '{1'b0,1'b0,1'b1,1'b1,3'd0,1'b0,1'b0,3'd0,8'h00,8'h00,1'b0}  // R1 word 0
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cycle_start = 1'b0;
    logic              wipe = 1'b0;
    logic              rd_phase = 1'b0;
    logic              rd_en = 1'b0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic              wr_phase = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              overlap_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    phased_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .wipe        (wipe),
        .rd_phase    (rd_phase),
        .rd_en       (rd_en),
        .rd_idx      (rd_idx),
        .wr_phase    (wr_phase),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .overlap_err (overlap_err)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive one clock at the falling edge, sample at the next falling edge
    task automatic step(input vec_t v);
        cycle_start = v.cs;  wipe = v.wp;
        rd_phase = v.rp;     rd_en = v.re;   rd_idx = v.ri;
        wr_phase = v.wph;    wr_en = v.we;   wr_idx = v.wi;  wr_data = v.wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic vec_t mk(input logic cs, input logic wp, input logic rd,
                                input logic [2:0] ri, input logic wr,
                                input logic [2:0] wi, input logic [7:0] wd);
        vec_t v;
        v = '{cs, wp, rd, rd, ri, wr, wr, wi, wd, 8'h00, 1'b0};
        return v;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R3 reset rd_data", rd_data, 8'hFF);
        check("R3 reset err", {7'd0, overlap_err}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 after release", rd_data, 8'hFF);

        for (int k = 0; k < NV; k++) begin
            step(TBL[k]);
            check($sformatf("table %0d rd_data", k), rd_data, TBL[k].exp_rd);
            check($sformatf("table %0d R9 err", k), {7'd0, overlap_err}, {7'd0, TBL[k].exp_err});
        end

        // R1: top index
        step(mk(1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd7, 8'h81));
        step(mk(1'b0, 1'b0, 1'b1, 3'd7, 1'b0, 3'd0, 8'h00));
        check("R1 top word", rd_data, 8'h81);
        step(mk(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00));
        check("R3 idle after read", rd_data, 8'hFF);

        // R5: wipe clock with a read of a written word
        step(mk(1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 8'h00));
        check("R5 read on wipe", rd_data, 8'h00);
        // R6: write after wipe, before cycle start, is dropped
        step(mk(1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 8'h55));
        step(mk(1'b0, 1'b0, 1'b1, 3'd7, 1'b0, 3'd0, 8'h00));
        check("R6 read held wipe", rd_data, 8'h00);
        step(mk(1'b1, 1'b0, 1'b1, 3'd3, 1'b0, 3'd0, 8'h00));
        check("R6 blocked write", rd_data, 8'h00);
        step(mk(1'b0, 1'b0, 1'b1, 3'd6, 1'b0, 3'd0, 8'h00));
        check("R5 word stays zero", rd_data, 8'h00);

        // R7: write on the releasing clock lands
        step(mk(1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00));
        step(mk(1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 8'h55));
        step(mk(1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 3'd0, 8'h00));
        check("R7 write at release", rd_data, 8'h55);

        // R6: cycle start together with wipe keeps it held
        step(mk(1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00));
        step(mk(1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd4, 8'hEE));
        step(mk(1'b1, 1'b0, 1'b1, 3'd4, 1'b0, 3'd0, 8'h00));
        check("R6 wipe with cycle start", rd_data, 8'h00);
        step(mk(1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 3'd0, 8'h00));
        check("R5 prior word cleared", rd_data, 8'h00);

        step(mk(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00));
        done = 1'b1;
        summary();
        $finish;
    end

endmodule